// File: doc/BRIEF.md
# Per-Pin Byte-Register GPIO Controller

This block is a general-purpose I/O controller addressed over a byte-wide register bus. Every pin owns one 8-bit control byte that carries its driven value, its last sampled input value and its direction. A short bank of read-only level bytes sits below the pin bytes in the address window. Software configures and reads pins through single-byte accesses.

When a pin is made an output by a write, its input bit copies the output value, so a read shows what the pin is driving. Input changes on the external pin vector are folded into the input bit of the matching byte. Two pins drive interrupt lines with fixed polarity. One is active-low and follows its pin level. The other follows its pin directly. A separate pulse request drives that second pin high for one cycle and then low, which gives a single interrupt pulse.

An input change on a pin that is currently driven as an output is still recorded. It also sets a sticky conflict flag, which stays set until reset.

Top module: `pbg_gpio_top`

## Requirements
- R1: A write to a pin byte stores written bits 7..3 and bit 0 (output value) and bit 2 (output enable) as given; the written bit 1 (input value) is never stored directly.
- R2: On a pin-byte write with bit 2 set, the stored bit 1 becomes the written bit 0; with bit 2 clear, the stored bit 1 keeps its previous value.
- R3: When bit p of `ext_pin` changes, bit 1 of pin byte p takes the new level on the next clock edge and no other bit changes; an unchanged input alters nothing.
- R4: Offsets 0..7 are level bytes that always read 0x00; writes to them change no stored state.
- R5: Offset 8+p holds pin byte p for p = 0..35; offsets 44 and above read 0x00 and ignore writes.
- R6: `bus_rdata` is registered: it shows the addressed byte one clock after a cycle with `bus_rd` high, and it holds its value in cycles without `bus_rd`.
- R7: Interrupt line 1 is high exactly while bit 1 of pin byte 1 is 0 (active-low level).
- R8: Interrupt line 9 is high exactly while bit 1 of pin byte 9 is 1.
- R9: A cycle with `pulse_req` high, when no pulse is in progress, makes line 9 high for exactly one cycle and low in the cycle after that.
- R10: After reset every pin byte is 0x00 except pin byte 1, which is 0x02; all interrupt lines, `bus_rdata` and `drive_conflict` are 0.
- R11: Interrupt lines 0, 2..8 are always 0.
- R12: An input change on a pin whose stored bit 2 is 1 is still recorded in bit 1 and sets `drive_conflict`, which then stays 1 until reset.
- R13: For bit 1 of pin byte 9 in a single cycle, the pulse sequence wins over an input change, and an input change wins over a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, takes effect on this clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| ext_pin | input | 36 | External pin levels, one per pin |
| pulse_req | input | 1 | Request for one high-then-low pulse on pin 9 |
| irq_out | output | 10 | Interrupt lines indexed by pin number |
| drive_conflict | output | 1 | Sticky flag: input changed on a pin driven as output |

## Verification
On every cycle the assertions check several things. The loopback of the output value into the input bit after an output-enabled write (R2) is checked in the pin cells. At the top level they check the line-1 response to an input change, the two-cycle shape of the pulse on line 9, the silence of unused lines, the stickiness of the conflict flag and the holding of read data. Other behaviours need the bench's scenarios and its reference model: the address decode with its level and undecoded holes, the discarded input bit on writes, the reset image, and the same-cycle priority between pulse, input change and write.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
   localparam int BIT_OUT = 0;
   localparam int BIT_IN  = 1;
   localparam int BIT_OE  = 2;
   localparam int BYTE_W  = 8;
   typedef logic [BYTE_W-1:0] ctl_byte_t;
endpackage

// File: rtl/pbg_pin_cell.sv
module pbg_pin_cell
   import pbg_pkg::*;
#(
   parameter ctl_byte_t RST_BYTE = '0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_hit,
   input  ctl_byte_t wdata,
   input  logic      ev,
   input  logic      ev_val,
   input  logic      force_hi,
   input  logic      force_lo,
   output ctl_byte_t q,
   output logic      conflict
);
   ctl_byte_t d;

   always_comb begin
      d = q;
      if (wr_hit) begin
         d = wdata;
         d[BIT_IN] = wdata[BIT_OE] ? wdata[BIT_OUT] : q[BIT_IN];
      end
      if (force_hi)      d[BIT_IN] = 1'b1;
      else if (force_lo) d[BIT_IN] = 1'b0;
      else if (ev)       d[BIT_IN] = ev_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_BYTE;
      else        q <= d;
   end

   assign conflict = ev & q[BIT_OE];

   assert_loopback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[BIT_OE] && !ev && !force_hi && !force_lo)
      |=> (q[BIT_IN] == $past(wdata[BIT_OUT])));
endmodule

// File: rtl/pbg_irq_map.sv
module pbg_irq_map #(
   parameter int NUM_IRQ   = 10,
   parameter int LOW_PIN   = 1,
   parameter int PULSE_PIN = 9
) (
   input  logic               low_in,
   input  logic               pulse_in,
   output logic [NUM_IRQ-1:0] irq
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      if (i == LOW_PIN) begin : g_low
         assign irq[i] = ~low_in;
      end else if (i == PULSE_PIN) begin : g_pulse
         assign irq[i] = pulse_in;
      end else begin : g_idle
         assign irq[i] = 1'b0;
      end
   end
endmodule

// File: rtl/pbg_read_port.sv
module pbg_read_port
   import pbg_pkg::*;
#(
   parameter int NUM_PINS   = 36,
   parameter int NUM_LEVELS = 8,
   parameter int ADDR_W     = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_PINS*BYTE_W-1:0] bytes_flat,
   output ctl_byte_t                  rdata
);
   ctl_byte_t rd_next;

   // level bytes and undecoded offsets fall through to zero
   always_comb begin
      rd_next = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (addr == ADDR_W'(p + NUM_LEVELS)) rd_next = bytes_flat[p*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_next;
   end
endmodule

// File: rtl/pbg_gpio_top.sv
module pbg_gpio_top
   import pbg_pkg::*;
#(
   parameter int NUM_PINS   = 36,
   parameter int NUM_LEVELS = 8,
   parameter int ADDR_W     = 6,
   parameter int NUM_IRQ    = 10,
   parameter int LOW_PIN    = 1,
   parameter int PULSE_PIN  = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [7:0]          bus_wdata,
   input  logic                bus_rd,
   output logic [7:0]          bus_rdata,
   input  logic [NUM_PINS-1:0] ext_pin,
   input  logic                pulse_req,
   output logic [NUM_IRQ-1:0]  irq_out,
   output logic                drive_conflict
);
   localparam logic [NUM_PINS-1:0] PINQ_RST  = NUM_PINS'(1) << LOW_PIN;
   localparam logic [NUM_IRQ-1:0]  USED_MASK = (NUM_IRQ'(1) << LOW_PIN) | (NUM_IRQ'(1) << PULSE_PIN);

   if (NUM_PINS + NUM_LEVELS > (1 << ADDR_W)) begin : g_chk_addr
      $error("address width too small for level and pin bytes");
   end
   if (LOW_PIN >= NUM_IRQ || PULSE_PIN >= NUM_IRQ || NUM_IRQ > NUM_PINS || LOW_PIN == PULSE_PIN) begin : g_chk_irq
      $error("interrupt pin selection out of range");
   end

   logic [NUM_PINS-1:0]        pin_q;
   logic [NUM_PINS-1:0]        ev;
   logic [NUM_PINS-1:0]        conflict;
   logic [NUM_PINS*BYTE_W-1:0] bytes_flat;
   logic                       pend_q;
   logic                       pulse_fire;
   logic                       flag_q;

   assign ev         = ext_pin ^ pin_q;
   assign pulse_fire = pulse_req & ~pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q  <= PINQ_RST;
         pend_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         pin_q  <= ext_pin;
         pend_q <= pulse_fire;
         flag_q <= flag_q | (|conflict);
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic fhi, flo;
      if (p == PULSE_PIN) begin : g_pulse
         assign fhi = pulse_fire;
         assign flo = pend_q;
      end else begin : g_plain
         assign fhi = 1'b0;
         assign flo = 1'b0;
      end
      pbg_pin_cell #(
         .RST_BYTE((p == LOW_PIN) ? ctl_byte_t'(8'h02) : ctl_byte_t'(8'h00))
      ) i_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (bus_wr && (bus_addr == ADDR_W'(p + NUM_LEVELS))),
         .wdata    (bus_wdata),
         .ev       (ev[p]),
         .ev_val   (ext_pin[p]),
         .force_hi (fhi),
         .force_lo (flo),
         .q        (bytes_flat[p*BYTE_W +: BYTE_W]),
         .conflict (conflict[p])
      );
   end

   pbg_irq_map #(
      .NUM_IRQ   (NUM_IRQ),
      .LOW_PIN   (LOW_PIN),
      .PULSE_PIN (PULSE_PIN)
   ) i_irq (
      .low_in   (bytes_flat[LOW_PIN*BYTE_W + BIT_IN]),
      .pulse_in (bytes_flat[PULSE_PIN*BYTE_W + BIT_IN]),
      .irq      (irq_out)
   );

   pbg_read_port #(
      .NUM_PINS   (NUM_PINS),
      .NUM_LEVELS (NUM_LEVELS),
      .ADDR_W     (ADDR_W)
   ) i_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (bus_rd),
      .addr       (bus_addr),
      .bytes_flat (bytes_flat),
      .rdata      (bus_rdata)
   );

   assign drive_conflict = flag_q;

   assert_low_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev[LOW_PIN] |=> (irq_out[LOW_PIN] == !$past(ext_pin[LOW_PIN])));
   assert_pulse_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_req && !pend_q) |=> irq_out[PULSE_PIN]);
   assert_pulse_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> !irq_out[PULSE_PIN]);
   assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~USED_MASK) == '0);
   assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      drive_conflict |=> drive_conflict);
   assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_pbg_gpio_top.sv
`timescale 1ns/1ps
module test_pbg_gpio_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        wr = 1'b0;
   logic [7:0]  wd = '0;
   logic        rd = 1'b0;
   logic [7:0]  rdata;
   logic [35:0] pins = 36'h2;
   logic        nmi = 1'b0;
   logic [9:0]  irq;
   logic        flag;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   bit live  = 0;

   // reference model state
   logic [7:0]  mreg [36];
   logic [35:0] mpin;
   logic        mpend;
   logic        mflag;
   logic [7:0]  mrd;

   always #4 clk = ~clk;

   pbg_gpio_top i_pbg_gpio_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wd),
      .bus_rd(rd), .bus_rdata(rdata), .ext_pin(pins), .pulse_req(nmi),
      .irq_out(irq), .drive_conflict(flag));

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 36; p++) mreg[p] = (p == 1) ? 8'h02 : 8'h00;
         mpin = 36'h2; mpend = 0; mflag = 0; mrd = 0; live = 0;
      end else begin
         logic [7:0] old [36];
         for (int p = 0; p < 36; p++) old[p] = mreg[p];
         if (rd) mrd = (addr >= 8 && addr < 44) ? old[addr - 8] : 8'h00;
         for (int p = 0; p < 36; p++) begin
            logic [7:0] n;
            bit chg;
            chg = pins[p] != mpin[p];
            n = old[p];
            if (wr && addr == p + 8) begin
               n = wd;
               n[1] = wd[2] ? wd[0] : old[p][1];
            end
            if (chg && old[p][2]) mflag = 1;
            if (p == 9 && mpend)     n[1] = 1'b0;
            else if (p == 9 && nmi)  n[1] = 1'b1;
            else if (chg)            n[1] = pins[p];
            mreg[p] = n;
         end
         mpend = mpend ? 1'b0 : nmi;
         mpin = pins;
         live = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && live) begin
         logic [9:0] ei;
         ei = '0;
         ei[1] = !mreg[1][1];
         ei[9] = mreg[9][1];
         chk("R6 rdata vs model", rdata, mrd);
         chk("R7 R8 R11 irq vs model", irq, ei);
         chk("R12 conflict flag vs model", flag, mflag);
      end
   end

   task automatic wr_b(logic [5:0] a, logic [7:0] d);
      addr = a; wd = d; wr = 1;
      @(negedge clk);
      wr = 0;
   endtask

   task automatic rd_chk(string tag, logic [5:0] a, int exp);
      addr = a; rd = 1;
      @(negedge clk);
      rd = 0;
      chk(tag, rdata, exp);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R10 irq after reset", irq, 0);
      chk("R10 flag after reset", flag, 0);
      chk("R10 rdata after reset", rdata, 0);
      rd_chk("R10 pin1 byte", 6'd9, 8'h02);
      rd_chk("R10 pin0 byte", 6'd8, 8'h00);

      wr_b(6'd10, 8'hF5);
      rd_chk("R2 output-enable loopback", 6'd10, 8'hF7);
      wr_b(6'd10, 8'hFA);
      rd_chk("R2 input bit kept", 6'd10, 8'hFA);
      @(negedge clk);
      chk("R6 rdata held", rdata, 8'hFA);
      wr_b(6'd11, 8'h02);
      rd_chk("R1 written input bit dropped", 6'd11, 8'h00);
      wr_b(6'd43, 8'h81);
      rd_chk("R5 last pin byte", 6'd43, 8'h81);
      wr_b(6'd45, 8'hFF);
      rd_chk("R5 undecoded offset", 6'd45, 8'h00);
      wr_b(6'd3, 8'hFF);
      rd_chk("R4 level byte reads zero", 6'd3, 8'h00);
      rd_chk("R4 level write left pin byte", 6'd11, 8'h00);

      pins[5] = 1;
      @(negedge clk);
      rd_chk("R3 input change recorded", 6'd13, 8'h02);

      pins[1] = 0;
      @(negedge clk);
      chk("R7 low-level irq asserted", irq[1], 1);
      pins[1] = 1;
      @(negedge clk);
      chk("R7 low-level irq released", irq[1], 0);

      pins[9] = 1;
      @(negedge clk);
      chk("R8 follower irq high", irq[9], 1);
      pins[9] = 0;
      @(negedge clk);
      chk("R8 follower irq low", irq[9], 0);

      nmi = 1;
      @(negedge clk);
      nmi = 0;
      chk("R9 pulse high", irq[9], 1);
      @(negedge clk);
      chk("R9 pulse low", irq[9], 0);

      wr_b(6'd12, 8'h04);
      pins[4] = 1;
      @(negedge clk);
      chk("R12 conflict set", flag, 1);
      rd_chk("R12 input recorded on output pin", 6'd12, 8'h06);
      repeat (3) @(negedge clk);
      chk("R12 conflict sticky", flag, 1);

      nmi = 1; pins[9] = 1;
      @(negedge clk);
      nmi = 0;
      chk("R13 pulse with input change high", irq[9], 1);
      @(negedge clk);
      chk("R13 pulse beats input level", irq[9], 0);
      pins[9] = 0;
      @(negedge clk);

      for (int i = 0; i < 3000; i++) begin
         addr = 6'($urandom_range(0, 63));
         wd   = 8'($urandom);
         wr   = ($urandom_range(0, 3) == 0);
         rd   = ($urandom_range(0, 1) == 0);
         nmi  = ($urandom_range(0, 15) == 0);
         if ($urandom_range(0, 3) == 0) pins[$urandom_range(0, 35)] ^= 1'b1;
         if ($urandom_range(0, 7) == 0) pins[9] ^= 1'b1;
         @(negedge clk);
      end
      wr = 0; rd = 0; nmi = 0;
      @(negedge clk);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule